// File: doc/BRIEF.md
# Touch Sample FIFO with Status

This block buffers the measurement words of a touch panel front end until a host collects them. A conversion sequencer presents one sample at a time: a pen-level flag, an X code and a Y code. The block packs each sample into a 32-bit word and stores it in a small first-in first-out buffer, four entries deep by default.

The host sees three word registers behind a two-bit address with separate read and write strobes:

- a status word, which reports whether the buffer is empty and whether a sample was lost;
- a control word, whose single bit picks the interrupt threshold;
- a data register, where each read removes the oldest entry.

A level interrupt stays high while enough entries are waiting. To flush the buffer, the host keeps reading the data register until the status word reports empty.

Top module: `tsf_top`

## Requirements
- R1: A stored word holds the pen flag in bit 31, the X code in bits 25:16 and the Y code in bits 9:0. Bits 30:26 and 15:10 read as zero.
- R2: A read with address 2 returns the oldest stored entry and removes it, so entries come back in the order they were written. Read data appears on host_rdata one clock after the read strobe and holds until the next read.
- R3: A read with address 0 returns the status word. Bit 7 is 1 while the buffer holds no entries, bit 8 is the overrun flag, and all other bits are 0.
- R4: A sample presented while the buffer holds DEPTH entries, with no pop in the same cycle, is discarded. The stored entries are unchanged, and the overrun flag sets.
- R5: The overrun flag stays set until a pop leaves the buffer empty. That pop clears it.
- R6: A read with address 2 while the buffer is empty returns zero and removes nothing. A sample written afterwards is the next one returned.
- R7: Bit 0 of the control word (address 1) selects the interrupt threshold: 0 selects one entry, 1 selects DEPTH entries. irq is high exactly while the entry count is at or above the threshold, and it follows the count in the same cycle that the count changes.
- R8: When the buffer is full, a sample and a data read in the same cycle are both accepted. No overrun is flagged, and the count stays at DEPTH.
- R9: After reset the buffer is empty, the overrun flag is 0, the control bit is 0, irq is 0 and host_rdata is 0.
- R10: A read with address 1 returns the control bit in bit 0 and zero elsewhere. A read with address 3 returns zero. A write takes effect only with address 1.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| smp_valid | input | 1 | Sample strobe from the sequencer |
| smp_pen | input | 1 | Pen-level flag of the sample |
| smp_x | input | 10 | X code of the sample |
| smp_y | input | 10 | Y code of the sample |
| host_rd | input | 1 | Host read strobe |
| host_wr | input | 1 | Host write strobe |
| host_addr | input | 2 | Register select: 0 status, 1 control, 2 data, 3 reserved |
| host_wdata | input | 1 | Write data for the control bit |
| host_rdata | output | 32 | Registered read data |
| irq | output | 1 | Level interrupt, count at or above threshold |

## Verification
The bench builds the block with its defaults: four entries and 10-bit coordinates. At that depth, random pushes and reads fill the buffer often. This reaches the overrun set and clear path, simultaneous push and pop while full, and empty reads many times, and it exercises both threshold settings of the interrupt. Directed sequences pin down the exact words returned after an overrun, and they pin down the cycle where irq rises at the DEPTH threshold.

// File: rtl/tsf_pkg.sv
package tsf_pkg;
  localparam int ENTRY_W   = 32;
  localparam int COORD_W   = 10;
  localparam int PEN_POS   = 31;
  localparam int X_LSB     = 16;
  localparam int Y_LSB     = 0;
  localparam int EMPTY_POS = 7;
  localparam int OVR_POS   = 8;
  localparam int REG_AW    = 2;

  typedef enum logic [REG_AW-1:0] {
    REG_STATUS = 2'd0,
    REG_CTRL   = 2'd1,
    REG_DATA   = 2'd2,
    REG_SPARE  = 2'd3
  } reg_sel_e;
endpackage

// File: rtl/tsf_pack.sv
module tsf_pack #(
  parameter int WORD_W  = 32,
  parameter int COORD_W = 10,
  parameter int PEN_POS = 31,
  parameter int X_LSB   = 16,
  parameter int Y_LSB   = 0
) (
  input  logic               pen,
  input  logic [COORD_W-1:0] x_code,
  input  logic [COORD_W-1:0] y_code,
  output logic [WORD_W-1:0]  word
);
  always_comb begin
    word                   = '0;
    word[PEN_POS]          = pen;
    word[X_LSB +: COORD_W] = x_code;
    word[Y_LSB +: COORD_W] = y_code;
  end
endmodule

// File: rtl/tsf_store.sv
module tsf_store #(
  parameter int WIDTH = 32,
  parameter int DEPTH = 4,
  localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int CNT_W = $clog2(DEPTH + 1)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             push,
  input  logic             pop_req,
  input  logic [WIDTH-1:0] din,
  output logic [WIDTH-1:0] head,
  output logic [CNT_W-1:0] cnt_q,
  output logic [CNT_W-1:0] cnt_nxt,
  output logic             empty,
  output logic             accept,
  output logic             pop,
  output logic             drop
);
  logic [WIDTH-1:0] mem [DEPTH];
  logic [PTR_W-1:0] wptr_q, rptr_q;
  logic             full;

  function automatic logic [PTR_W-1:0] bump(input logic [PTR_W-1:0] p);
    return (p == PTR_W'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  assign empty  = (cnt_q == '0);
  assign full   = (cnt_q == CNT_W'(DEPTH));
  assign pop    = pop_req && !empty;
  assign accept = push && (!full || pop);
  assign drop   = push && full && !pop;

  always_comb begin
    unique case ({accept, pop})
      2'b10:   cnt_nxt = cnt_q + 1'b1;
      2'b01:   cnt_nxt = cnt_q - 1'b1;
      default: cnt_nxt = cnt_q;
    endcase
  end

  // storage array without reset so it maps to distributed memory
  always_ff @(posedge clk) begin
    if (accept) mem[wptr_q] <= din;
  end

  assign head = mem[rptr_q];

  always_ff @(posedge clk) begin
    if (rst) begin
      wptr_q <= '0;
      rptr_q <= '0;
      cnt_q  <= '0;
    end else begin
      if (accept) wptr_q <= bump(wptr_q);
      if (pop)    rptr_q <= bump(rptr_q);
      cnt_q <= cnt_nxt;
    end
  end
endmodule

// File: rtl/tsf_status.sv
module tsf_status #(
  parameter int DEPTH     = 4,
  parameter int LOW_LEVEL = 1,
  localparam int CNT_W    = $clog2(DEPTH + 1)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             drop,
  input  logic             pop,
  input  logic [CNT_W-1:0] cnt_nxt,
  input  logic             thr_full_nxt,
  output logic             ovr_q,
  output logic             irq_q
);
  logic [CNT_W-1:0] thr;

  assign thr = thr_full_nxt ? CNT_W'(DEPTH) : CNT_W'(LOW_LEVEL);

  always_ff @(posedge clk) begin
    if (rst) begin
      ovr_q <= 1'b0;
      irq_q <= 1'b0;
    end else begin
      if (drop)
        ovr_q <= 1'b1;
      else if (pop && cnt_nxt == '0)
        ovr_q <= 1'b0;
      irq_q <= (cnt_nxt >= thr);
    end
  end
endmodule

// File: rtl/tsf_top.sv
module tsf_top
  import tsf_pkg::*;
#(
  parameter int DEPTH = 4,
  localparam int CNT_W = $clog2(DEPTH + 1)
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               smp_valid,
  input  logic               smp_pen,
  input  logic [COORD_W-1:0] smp_x,
  input  logic [COORD_W-1:0] smp_y,
  input  logic               host_rd,
  input  logic               host_wr,
  input  logic [REG_AW-1:0]  host_addr,
  input  logic               host_wdata,
  output logic [ENTRY_W-1:0] host_rdata,
  output logic               irq
);
  logic [ENTRY_W-1:0] packed_w, head, status_w;
  logic [CNT_W-1:0]   cnt_q, cnt_nxt;
  logic               empty, accept, pop, drop, ovr_q;
  logic               ctrl_q, ctrl_nxt, data_rd;
  reg_sel_e           sel;

  assign sel      = reg_sel_e'(host_addr);
  assign data_rd  = host_rd && (sel == REG_DATA);
  assign ctrl_nxt = (host_wr && sel == REG_CTRL) ? host_wdata : ctrl_q;

  tsf_pack #(
    .WORD_W(ENTRY_W), .COORD_W(COORD_W), .PEN_POS(PEN_POS),
    .X_LSB(X_LSB), .Y_LSB(Y_LSB)
  ) u_pack (
    .pen(smp_pen), .x_code(smp_x), .y_code(smp_y), .word(packed_w)
  );

  tsf_store #(.WIDTH(ENTRY_W), .DEPTH(DEPTH)) u_store (
    .clk(clk), .rst(rst), .push(smp_valid), .pop_req(data_rd),
    .din(packed_w), .head(head), .cnt_q(cnt_q), .cnt_nxt(cnt_nxt),
    .empty(empty), .accept(accept), .pop(pop), .drop(drop)
  );

  tsf_status #(.DEPTH(DEPTH), .LOW_LEVEL(1)) u_status (
    .clk(clk), .rst(rst), .drop(drop), .pop(pop), .cnt_nxt(cnt_nxt),
    .thr_full_nxt(ctrl_nxt), .ovr_q(ovr_q), .irq_q(irq)
  );

  always_comb begin
    status_w            = '0;
    status_w[EMPTY_POS] = empty;
    status_w[OVR_POS]   = ovr_q;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      ctrl_q     <= 1'b0;
      host_rdata <= '0;
    end else begin
      ctrl_q <= ctrl_nxt;
      if (host_rd) begin
        unique case (sel)
          REG_STATUS: host_rdata <= status_w;
          REG_CTRL:   host_rdata <= {{(ENTRY_W-1){1'b0}}, ctrl_q};
          REG_DATA:   host_rdata <= empty ? '0 : head;
          default:    host_rdata <= '0;
        endcase
      end
    end
  end
endmodule

// File: rtl/tsf_checker.sv
module tsf_checker #(
  parameter int DEPTH = 4,
  parameter int CNT_W = 3
) (
  input logic             clk,
  input logic             rst,
  input logic             smp_valid,
  input logic             host_rd,
  input logic [1:0]       host_addr,
  input logic [31:0]      host_rdata,
  input logic             irq,
  input logic [CNT_W-1:0] cnt_q,
  input logic             ovr_q,
  input logic             ctrl_q
);
  a_r2_count_bound: assert property (@(posedge clk) disable iff (rst)
    cnt_q <= CNT_W'(DEPTH));

  a_r1_pad_zero: assert property (@(posedge clk) disable iff (rst)
    host_rdata[30:26] == 5'd0 && host_rdata[15:10] == 6'd0);

  a_r6_empty_read_zero: assert property (@(posedge clk) disable iff (rst)
    (host_rd && host_addr == 2'd2 && cnt_q == '0) |=> host_rdata == 32'd0);

  a_r4_overrun_cause: assert property (@(posedge clk) disable iff (rst)
    $rose(ovr_q) |-> $past(smp_valid && cnt_q == CNT_W'(DEPTH)));

  a_r5_overrun_clear: assert property (@(posedge clk) disable iff (rst)
    $fell(ovr_q) |-> cnt_q == '0);

  a_r7_irq_level: assert property (@(posedge clk) disable iff (rst)
    irq == (cnt_q >= (ctrl_q ? CNT_W'(DEPTH) : CNT_W'(1))));
endmodule

bind tsf_top tsf_checker #(.DEPTH(DEPTH), .CNT_W(CNT_W)) u_chk (
  .clk(clk), .rst(rst), .smp_valid(smp_valid), .host_rd(host_rd),
  .host_addr(host_addr), .host_rdata(host_rdata), .irq(irq),
  .cnt_q(cnt_q), .ovr_q(ovr_q), .ctrl_q(ctrl_q)
);

// File: tb/tb_tsf_top.sv
module tb_tsf_top;
  localparam int DEPTH = 4;
  localparam time PERIOD = 20ns;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        smp_valid = 1'b0, smp_pen = 1'b0;
  logic [9:0]  smp_x = '0, smp_y = '0;
  logic        host_rd = 1'b0, host_wr = 1'b0, host_wdata = 1'b0;
  logic [1:0]  host_addr = '0;
  logic [31:0] host_rdata;
  logic        irq;

  int n_checks = 0;
  int n_err = 0;
  bit done = 0;

  logic [31:0] q[$];
  logic        ovr_m = 1'b0;
  logic        ctrl_m = 1'b0;
  logic [31:0] exp_rd = '0;

  always #(PERIOD/2) clk = ~clk;

  tsf_top #(.DEPTH(DEPTH)) dut (
    .clk(clk), .rst(rst), .smp_valid(smp_valid), .smp_pen(smp_pen),
    .smp_x(smp_x), .smp_y(smp_y), .host_rd(host_rd), .host_wr(host_wr),
    .host_addr(host_addr), .host_wdata(host_wdata),
    .host_rdata(host_rdata), .irq(irq)
  );

  function automatic logic [31:0] pack(input logic p, input logic [9:0] x, input logic [9:0] y);
    return {p, 5'b0, x, 6'b0, y};
  endfunction

  function automatic logic [31:0] status_m();
    logic [31:0] s = '0;
    s[8] = ovr_m;
    s[7] = (q.size() == 0);
    return s;
  endfunction

  task automatic check(input string tag, input logic [31:0] got, input logic [31:0] exp);
    n_checks++;
    if (got !== exp) begin
      n_err++;
      $display("FAIL %s got %h exp %h", tag, got, exp);
    end
  endtask

  // one cycle: drive at negedge, model at posedge, check at next negedge
  task automatic step(input logic pv, input logic pen, input logic [9:0] x, input logic [9:0] y,
                      input logic rd, input logic wr, input logic [1:0] a, input logic wd,
                      input string tag = "");
    int sz;
    logic pop, full, acc;
    string t;
    smp_valid = pv; smp_pen = pen; smp_x = x; smp_y = y;
    host_rd = rd; host_wr = wr; host_addr = a; host_wdata = wd;
    @(posedge clk);
    sz = q.size();
    pop = rd && a == 2'd2 && sz > 0;
    full = (sz == DEPTH);
    acc = pv && (!full || pop);
    if (rd) begin
      case (a)
        2'd0: exp_rd = status_m();
        2'd1: exp_rd = {31'b0, ctrl_m};
        2'd2: exp_rd = (sz > 0) ? q[0] : 32'd0;
        default: exp_rd = 32'd0;
      endcase
    end
    if (pop) void'(q.pop_front());
    if (acc) q.push_back(pack(pen, x, y));
    if (pv && full && !pop) ovr_m = 1'b1;
    else if (pop && !acc && sz == 1) ovr_m = 1'b0;
    if (wr && a == 2'd1) ctrl_m = wd;
    @(negedge clk);
    smp_valid = 1'b0; host_rd = 1'b0; host_wr = 1'b0;
    check("R7 irq", {31'b0, irq}, {31'b0, (q.size() >= (ctrl_m ? DEPTH : 1))});
    if (rd) begin
      if (tag != "") t = tag;
      else if (a == 2'd0) t = "R3 status";
      else if (a == 2'd2 && sz == 0) t = "R6 empty read";
      else if (a == 2'd2) t = "R2 data";
      else t = "R10 ctrl/spare";
      check(t, host_rdata, exp_rd);
    end
  endtask

  task automatic push_s(input logic pen, input logic [9:0] x, input logic [9:0] y);
    step(1'b1, pen, x, y, 1'b0, 1'b0, 2'd0, 1'b0);
  endtask

  task automatic rd_reg(input logic [1:0] a, input string tag = "");
    step(1'b0, 1'b0, 10'd0, 10'd0, 1'b1, 1'b0, a, 1'b0, tag);
  endtask

  initial begin
    #(PERIOD * 200000);
    if (!done) begin
      n_checks++;
      n_err++;
      $display("FAIL R2 watchdog got hang exp completion");
      $display("Simulation finished: %0d checks, %0d errors", n_checks, n_err);
      $finish;
    end
  end

  initial begin
    logic [31:0] r;
    r = $urandom(32'd7321);
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R9 reset state
    check("R9 rdata reset", host_rdata, 32'd0);
    check("R9 irq reset", {31'b0, irq}, 32'd0);
    rd_reg(2'd0, "R9 status reset");
    rd_reg(2'd1, "R9 ctrl reset");

    // R6 empty read, then pointers intact
    rd_reg(2'd2, "R6 empty read zero");
    push_s(1'b1, 10'h3FF, 10'h3FF);
    rd_reg(2'd2, "R1 pack all ones");
    push_s(1'b0, 10'h155, 10'h2AA);
    rd_reg(2'd2, "R1 pack pattern");

    // R10 register map details
    step(1'b0, 1'b0, 10'd0, 10'd0, 1'b0, 1'b1, 2'd3, 1'b1);
    rd_reg(2'd1, "R10 spare write ignored");
    rd_reg(2'd3, "R10 spare reads zero");

    // R7 threshold at DEPTH
    step(1'b0, 1'b0, 10'd0, 10'd0, 1'b0, 1'b1, 2'd1, 1'b1);
    rd_reg(2'd1, "R10 ctrl readback");
    for (int i = 0; i < DEPTH; i++) push_s(i[0], 10'(i * 37), 10'(1000 - i));
    // R4 drop while full
    push_s(1'b1, 10'h111, 10'h222);
    rd_reg(2'd0, "R4 overrun flagged");
    for (int i = 0; i < DEPTH - 1; i++) begin
      rd_reg(2'd2, "R4 entries intact");
      rd_reg(2'd0, "R5 overrun sticky");
    end
    rd_reg(2'd2, "R4 last entry intact");
    rd_reg(2'd0, "R5 overrun cleared on empty");

    // R8 push and pop together while full
    for (int i = 0; i < DEPTH; i++) push_s(1'b0, 10'(i + 5), 10'(i + 9));
    step(1'b1, 1'b1, 10'h0AB, 10'h0CD, 1'b1, 1'b0, 2'd2, 1'b0, "R8 pop while full");
    rd_reg(2'd0, "R8 no overrun");
    for (int i = 0; i < DEPTH; i++) rd_reg(2'd2, "R8 order after swap");
    step(1'b0, 1'b0, 10'd0, 10'd0, 1'b0, 1'b1, 2'd1, 1'b0);

    // random traffic
    for (int i = 0; i < 3000; i++) begin
      logic pv, rd, wr, wd;
      logic [1:0] a;
      r = $urandom;
      pv = (r[2:0] < 3'd4);
      rd = (r[5:3] < 3'd4);
      wr = (r[9:6] == 4'd0);
      a  = r[11] ? 2'd2 : r[13:12];
      wd = r[14];
      step(pv, r[15], r[25:16], $urandom_range(0, 1023), rd, wr, a, wd);
    end

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", n_checks, n_err);
    $finish;
  end
endmodule